// File: doc/BRIEF.md
# Serial Gain Chain Loader

This block sets the gains of sixteen channels. The gains sit in a chain of eight serial dual-potentiometer devices. A host writes one 8-bit gain per channel into a local register bank and then issues a start command. The block takes a snapshot of the whole bank. It then sends that snapshot as one 136-bit serial stream on three lines: an enable line, a serial clock and a serial data line. Every update reloads all sixteen gains, even when only one of them has changed.

Each device takes 17 bits: a leading stack-select bit that is always zero, then the gains of two channels. Devices are fed from the highest channel pair down, so channel 15 is sent first and channel 0 last. Each gain goes most significant bit first. The enable line rises before the first bit and stays high for the whole stream. Its fall after the last bit latches the new settings in every device. A one-cycle done pulse follows once the enable line has been low for one clock phase.

For bring-up, a direct mode hands the three lines to a 3-bit host register.

Top module: `gain_chain_loader`

## Requirements
- R1: After reset, potEn, potClk, potDat, busy and done are all 0.
- R2: A start command with bangMode at 0 produces exactly 136 rising edges of potClk, and potEn is high at every one of them.
- R3: At the rising edge for stream bit k, potDat is 0 whenever k mod 17 equals 0. This is the stack-select bit of each device.
- R4: For every other bit k, with d = k/17 and p = k mod 17, potDat equals bit (7 - (p-1) mod 8) of the gain of channel 15 - (2d + (p-1)/8). Channels are therefore sent in descending order, each most significant bit first.
- R5: Each potClk high pulse lasts PHASE_CYC cycles, and the low time between pulses is PHASE_CYC cycles. potDat does not change in the cycle before a rising edge or while potClk is high.
- R6: potEn falls only after the 136th pulse, once potClk has been low for PHASE_CYC cycles.
- R7: busy is high from the cycle after an accepted start until done. A start command while busy is ignored.
- R8: Gain writes made while busy do not change the stream in progress. They are used by the next start.
- R9: done is high for exactly one cycle, PHASE_CYC cycles after potEn falls, and busy is low in that cycle.
- R10: With bangMode at 1, the bang register drives the lines: bit 0 drives potDat, bit 1 drives potClk and bit 2 drives potEn. The register is written by bangWr with bangData and takes effect on the next cycle. Start commands are ignored in this mode.
- R11: A write with wrEn stores wrGain as the gain of channel wrChan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Gain write strobe |
| wrChan | input | 4 | Channel index for a gain write |
| wrGain | input | 8 | Gain value to write |
| start | input | 1 | Request a full reload of all gains |
| bangMode | input | 1 | 1 hands the serial lines to the bang register |
| bangWr | input | 1 | Write strobe for the bang register |
| bangData | input | 3 | Bang register value: bit 0 data, bit 1 clock, bit 2 enable |
| potEn | output | 1 | Enable/reset line to the chain; its falling edge latches the gains |
| potClk | output | 1 | Serial clock, idles low |
| potDat | output | 1 | Serial data |
| busy | output | 1 | A reload is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check the following:
- potDat is steady before and during each clock high phase.
- The stack-select bit is zero whenever it is clocked.
- The enable line falls only once the last bit has gone out.
- done lasts one cycle.
- An accepted start raises busy.

Some behaviours need a decoded stream and can only be shown by the bench's scenarios:
- The channel-descending, MSB-first ordering of the gains.
- The exact count of 136 pulses.
- The phase lengths.
- The staging of writes made during a stream.
- The rejection of starts while busy or in direct mode.

// File: rtl/gl_pkg.sv
package gl_pkg;

  typedef struct packed {
    logic load;
    logic shift;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEAD,
    S_HIGH,
    S_LOW,
    S_TAIL,
    S_DROP
  } seqState_t;

endpackage

// File: rtl/gl_datapath.sv
module gl_datapath
  import gl_pkg::*;
#(
  parameter int NUM_CHAN      = 16,
  parameter int GAIN_W        = 8,
  parameter int CHANS_PER_DEV = 2,
  parameter int CH_W          = $clog2(NUM_CHAN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CH_W-1:0]   wrChan,
  input  logic [GAIN_W-1:0] wrGain,
  input  dpStrobe_t         strobe,
  output logic              serDat
);

  localparam int NUM_DEV  = NUM_CHAN / CHANS_PER_DEV;
  localparam int DEV_BITS = 1 + CHANS_PER_DEV * GAIN_W;
  localparam int TOTAL    = NUM_DEV * DEV_BITS;

  logic [GAIN_W-1:0] hostGain [NUM_CHAN];
  logic [TOTAL-1:0]  framed;
  logic [TOTAL-1:0]  streamReg;

  // Host bank: always writable; the stream works from its own snapshot.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CHAN; i++) hostGain[i] <= '0;
    end else if (wrEn) begin
      hostGain[wrChan] <= wrGain;
    end
  end

  // Arrange the bank in transmit order; the MSB of framed goes out first.
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    assign framed[TOTAL-1-d*DEV_BITS] = 1'b0;
    for (genvar c = 0; c < CHANS_PER_DEV; c++) begin : g_chan
      for (genvar b = 0; b < GAIN_W; b++) begin : g_bit
        assign framed[TOTAL-1-(d*DEV_BITS+1+c*GAIN_W+b)] =
          hostGain[NUM_CHAN-1-(d*CHANS_PER_DEV+c)][GAIN_W-1-b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      streamReg <= '0;
    end else if (strobe.load) begin
      streamReg <= framed;
    end else if (strobe.shift) begin
      streamReg <= {streamReg[TOTAL-2:0], 1'b0};
    end
  end

  assign serDat = streamReg[TOTAL-1];

endmodule

// File: rtl/gl_sequencer.sv
module gl_sequencer
  import gl_pkg::*;
#(
  parameter int TOTAL     = 136,
  parameter int DEV_BITS  = 17,
  parameter int PHASE_CYC = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  output dpStrobe_t strobe,
  output logic      seqEn,
  output logic      seqClk,
  output logic      stackBit,
  output logic      busy,
  output logic      done
);

  localparam int PH_W  = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam int BIT_W = $clog2(TOTAL);
  localparam int POS_W = $clog2(DEV_BITS);

  seqState_t        state;
  logic [PH_W-1:0]  phCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [POS_W-1:0] posCnt;
  logic             phaseEnd;
  logic             lastBit;

  assign phaseEnd = (phCnt == PH_W'(PHASE_CYC - 1));
  assign lastBit  = (bitCnt == BIT_W'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      phCnt  <= '0;
      bitCnt <= '0;
      posCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        phCnt <= '0;
        if (startReq) begin
          state  <= S_LEAD;
          bitCnt <= '0;
          posCnt <= '0;
        end
      end else begin
        phCnt <= phaseEnd ? '0 : phCnt + 1'b1;
        if (phaseEnd) begin
          case (state)
            S_LEAD: state <= S_HIGH;
            S_HIGH: begin
              if (lastBit) begin
                state <= S_TAIL;
              end else begin
                state  <= S_LOW;
                bitCnt <= bitCnt + 1'b1;
                posCnt <= (posCnt == POS_W'(DEV_BITS - 1)) ? '0 : posCnt + 1'b1;
              end
            end
            S_LOW:  state <= S_HIGH;
            S_TAIL: state <= S_DROP;
            S_DROP: begin
              state <= S_IDLE;
              done  <= 1'b1;
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    strobe       = '0;
    strobe.load  = (state == S_IDLE) && startReq;
    strobe.shift = (state == S_HIGH) && phaseEnd && !lastBit;
  end

  assign seqClk   = (state == S_HIGH);
  assign seqEn    = (state == S_LEAD) || (state == S_HIGH) ||
                    (state == S_LOW)  || (state == S_TAIL);
  assign busy     = (state != S_IDLE);
  assign stackBit = (posCnt == '0);

  p_done_one_cycle_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> busy);

  p_en_fall_last_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(seqEn) |-> lastBit);

endmodule

// File: rtl/gain_chain_loader.sv
module gain_chain_loader
  import gl_pkg::*;
#(
  parameter int NUM_CHAN      = 16,
  parameter int GAIN_W        = 8,
  parameter int CHANS_PER_DEV = 2,
  parameter int PHASE_CYC     = 4,
  parameter int CH_W          = $clog2(NUM_CHAN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CH_W-1:0]   wrChan,
  input  logic [GAIN_W-1:0] wrGain,
  input  logic              start,
  input  logic              bangMode,
  input  logic              bangWr,
  input  logic [2:0]        bangData,
  output logic              potEn,
  output logic              potClk,
  output logic              potDat,
  output logic              busy,
  output logic              done
);

  localparam int NUM_DEV  = NUM_CHAN / CHANS_PER_DEV;
  localparam int DEV_BITS = 1 + CHANS_PER_DEV * GAIN_W;
  localparam int TOTAL    = NUM_DEV * DEV_BITS;

  dpStrobe_t  strobe;
  logic       seqEn, seqClk, seqDat, stackBit, startReq;
  logic [2:0] bangReg;

  assign startReq = start && !bangMode;

  always_ff @(posedge clk) begin
    if (!rstN)       bangReg <= '0;
    else if (bangWr) bangReg <= bangData;
  end

  gl_sequencer #(
    .TOTAL(TOTAL), .DEV_BITS(DEV_BITS), .PHASE_CYC(PHASE_CYC)
  ) u_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .strobe(strobe),
    .seqEn(seqEn), .seqClk(seqClk), .stackBit(stackBit),
    .busy(busy), .done(done)
  );

  gl_datapath #(
    .NUM_CHAN(NUM_CHAN), .GAIN_W(GAIN_W), .CHANS_PER_DEV(CHANS_PER_DEV), .CH_W(CH_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrChan(wrChan), .wrGain(wrGain),
    .strobe(strobe), .serDat(seqDat)
  );

  assign potEn  = bangMode ? bangReg[2] : seqEn;
  assign potClk = bangMode ? bangReg[1] : seqClk;
  assign potDat = bangMode ? bangReg[0] : seqDat;

  p_dat_stable_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (seqClk && $past(seqClk)) |-> $stable(seqDat));

  p_dat_setup_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seqClk) |-> $stable(seqDat));

  p_stack_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (seqClk && stackBit) |-> !seqDat);

endmodule

// File: tb/sim_gain_chain_loader.sv
module sim_gain_chain_loader;

  localparam int CLK_PERIOD = 10;
  localparam int P          = 4;
  localparam int NBITS      = 136;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrChan = '0;
  logic [7:0] wrGain = '0;
  logic       start = 1'b0;
  logic       bangMode = 1'b0;
  logic       bangWr = 1'b0;
  logic [2:0] bangData = '0;
  logic       potEn, potClk, potDat, busy, done;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  gain_chain_loader #(.PHASE_CYC(P)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrChan(wrChan), .wrGain(wrGain),
    .start(start), .bangMode(bangMode), .bangWr(bangWr), .bangData(bangData),
    .potEn(potEn), .potClk(potClk), .potDat(potDat), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic expBit(input logic [7:0] g [16], input int k);
    int d = k / 17;
    int p = k % 17;
    if (p == 0) return 1'b0;
    return g[15 - (2*d + (p-1)/8)][7 - (p-1) % 8];
  endfunction

  task automatic writeGain(input int ch, input logic [7:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrChan = 4'(ch); wrGain = v;
    @(negedge clk);
    wrEn = 1'b0;
    model[ch] = v;
  endtask

  task automatic runStream(input int mode, input string tag);
    logic [7:0] expG [16];
    int rises = 0, hiLen = 0, loLen = 0, cyc = 0, fallCyc = -1, doneCyc = -1;
    int bitErr = 0, stackErr = 0, enLow = 0, hiBad = 0, loBad = 0, stabBad = 0;
    int busyBad = 0, fallRises = -1, fallLow = -1, wIdx = 0;
    bit startSent = 0, busyAtDone = 1;
    logic prevClk = 0, prevDat = 0, prevEn = 0;
    for (int c = 0; c < 16; c++) expG[c] = model[c];
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (cyc < 6000 && doneCyc < 0) begin
      if (!done && !busy) busyBad++;
      if (potClk && !prevClk) begin
        rises++;
        if (!potEn) enLow++;
        if (potDat !== prevDat) stabBad++;
        if (rises > 1 && loLen != P) loBad++;
        if (rises <= NBITS && potDat !== expBit(expG, rises-1)) begin
          if ((rises-1) % 17 == 0) stackErr++; else bitErr++;
        end
        hiLen = 1;
      end else if (potClk) begin
        hiLen++;
        if (potDat !== prevDat) stabBad++;
      end
      if (!potClk && prevClk) begin
        if (hiLen != P) hiBad++;
        loLen = 1;
      end else if (!potClk) loLen++;
      if (prevEn && !potEn) begin
        fallCyc = cyc; fallRises = rises; fallLow = loLen - 1;
      end
      if (done) begin
        doneCyc = cyc; busyAtDone = busy;
      end
      prevClk = potClk; prevDat = potDat; prevEn = potEn;
      // mode 1: rewrite all gains and retry start in mid-stream
      if (mode == 1 && rises >= 40 && wIdx < 16) begin
        wrEn = 1'b1; wrChan = 4'(wIdx); wrGain = ~expG[wIdx] ^ 8'h3C;
        model[wIdx] = ~expG[wIdx] ^ 8'h3C;
        wIdx++;
      end else wrEn = 1'b0;
      if (mode == 1 && rises == 60 && !startSent) begin
        start = 1'b1; startSent = 1;
      end else start = 1'b0;
      cyc++;
      @(negedge clk);
    end
    wrEn = 1'b0; start = 1'b0;
    check(rises == NBITS, "R2", {tag, " pulse count"}, rises, NBITS);
    check(enLow == 0, "R2", {tag, " enable low at a rise"}, enLow, 0);
    check(stackErr == 0, "R3", {tag, " stack bits"}, stackErr, 0);
    check(bitErr == 0, "R4", {tag, " gain bit order"}, bitErr, 0);
    check(hiBad == 0 && loBad == 0, "R5", {tag, " phase lengths"}, hiBad + loBad, 0);
    check(stabBad == 0, "R5", {tag, " data stability"}, stabBad, 0);
    check(fallRises == NBITS && fallLow == P, "R6", {tag, " enable fall point"},
          fallLow, P);
    check(busyBad == 0 && !busyAtDone, "R7", {tag, " busy window"}, busyBad, 0);
    check(doneCyc - fallCyc == P, "R9", {tag, " done delay"}, doneCyc - fallCyc, P);
    check(!done, "R9", {tag, " done width"}, int'(done), 0);
    if (mode == 1) begin
      int rose = 0;
      for (int i = 0; i < 6*P; i++) begin
        @(negedge clk);
        if (potEn || busy) rose++;
      end
      check(rose == 0, "R7", "start while busy ignored", rose, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 16; c++) model[c] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({potEn, potClk, potDat, busy, done} == 5'b0, "R1", "reset outputs",
          int'({potEn, potClk, potDat, busy, done}), 0);

    // R11: ascending pattern
    for (int c = 0; c < 16; c++) writeGain(c, 8'(c * 17));
    runStream(0, "R11 ascending");
    for (int c = 0; c < 16; c++) writeGain(c, 8'hFF);
    runStream(0, "all ones");
    for (int c = 0; c < 16; c++) writeGain(c, 8'h00);
    runStream(0, "all zeros");
    for (int c = 0; c < 16; c++) writeGain(c, 8'(1 << (c % 8)));
    runStream(0, "walking one");
    for (int c = 0; c < 16; c++) writeGain(c, 8'hA5 ^ 8'(c));
    // R8: mid-stream writes must not disturb this stream
    runStream(1, "R8 staged writes");
    runStream(0, "R8 staged values used");

    // R10: direct line control
    @(negedge clk); bangMode = 1'b1;
    for (int v = 0; v < 8; v++) begin
      bangWr = 1'b1; bangData = 3'(v);
      @(negedge clk); bangWr = 1'b0;
      check({potEn, potClk, potDat} == 3'(v), "R10", "bang lines",
            int'({potEn, potClk, potDat}), v);
    end
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (2*P) @(negedge clk);
    check(!busy && {potEn, potClk, potDat} == 3'd7, "R10", "start ignored in bang mode",
          int'({busy, potEn, potClk, potDat}), 7);
    bangMode = 1'b0;
    @(negedge clk);
    check({potEn, potClk, potDat} == 3'd0, "R10", "lines idle after bang mode",
          int'({potEn, potClk, potDat}), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule